// File: doc/BRIEF.md
# Occupancy-Aware Virtual Channel Allocator

This block is the virtual-channel allocation stage of one mesh router. Every input VC that holds a routed head flit presents a request. The request carries a primary output port and, if it has one, a second output port, along with a flag that marks the packet as restricted to dimension-order routing. The block tracks every output VC. For each one it counts free downstream flit slots (credits) and the number of packets that currently reside in it. Several packets may share one output VC as long as it has room.

Allocation is separable and takes two stages. In the first stage, each requester looks at the VCs it is allowed to use on its candidate ports. It counts one full-buffer encounter for each candidate port on which every eligible VC is full, and it picks the non-full eligible VC that holds the fewest packets. In the second stage, a round-robin arbiter for each output VC grants one of the requesters that picked that VC. The updated full-buffer count comes back on the grant so that upstream logic can write it into the head flit.

Grants are combinational from the registered occupancy state. A grant raises the packet count of its VC at the next clock edge.

Top module: `occ_vc_alloc`

## Requirements
- R1: After reset every output VC holds DEPTH credits and zero packets, and no grant is given without a request. The first request to a port is therefore served by its lowest eligible VC, and its full-buffer count is returned unchanged.
- R2: The output VC for port p and VC v has index o = p*NV + v. `crd_take[o]` removes one credit and `crd_give[o]` returns one. A VC is full while its credits are zero or its packet count equals DEPTH, and a full VC is never granted.
- R3: A VC that already holds packets but is not full can be granted to a further packet.
- R4: `gr_fob` equals `rq_fob` plus one for each candidate port whose eligible VCs are all full. It saturates at 2^FW-1 and is valid whenever the request is valid, granted or not.
- R5: When every eligible VC on the primary port is full and a second port is allowed, the grant goes to the second port.
- R6: When both candidate ports are full, no grant is given and `gr_fob` is `rq_fob` plus two.
- R7: Among the non-full eligible candidate VCs, the one with the fewest packets is chosen. A tie goes to the primary port before the second port, and within a port to the lower VC number.
- R8: VCs numbered below ESC are escape VCs. A request with `rq_dor`=1 may use every VC of its primary port and its second port is ignored. A request with `rq_dor`=0 may use only VCs numbered ESC and above.
- R9: A VC's packet count rises by one on the clock edge after it is granted and falls by one on the edge where `pkt_leave` for it is high.
- R10: When several requesters pick the same output VC, that VC's arbiter grants in rotating order. Priority moves to the requester after the last winner.
- R11: Each output VC is granted to at most one requester per cycle. Requesters that pick different output VCs are all granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_valid | input | NI | Request present, one bit per input VC |
| rq_dor | input | NI | Packet restricted to dimension-order routing |
| rq_alt_ok | input | NI | Second candidate port is valid |
| rq_port_a | input | NI*PW | Primary candidate output port per requester |
| rq_port_b | input | NI*PW | Second candidate output port per requester |
| rq_fob | input | NI*FW | Full-buffer count carried in the head flit |
| crd_take | input | NO | One flit sent into output VC o |
| crd_give | input | NO | One credit returned for output VC o |
| pkt_leave | input | NO | A tail flit has left output VC o downstream |
| gr_valid | output | NI | Grant per requester |
| gr_port | output | NI*PW | Granted output port |
| gr_vc | output | NI*VW | Granted VC within the port |
| gr_fob | output | NI*FW | Updated full-buffer count |

## Verification
A wrong credit or packet count does not raise an error signal. It shows up at the ports in two ways: the VC that a later request picks, and the value of `gr_fob`. A leaked credit first appears as a spurious full encounter, which sends the packet to the other port and adds one to `gr_fob`. A miscount of packets first appears as a changed choice between two non-full VCs. Either effect appears in the combinational grant of the first request after the bad update, which is one cycle after the faulty edge. The directed scenarios exhaust credits and packet slots on purpose and check that each grant lands exactly where the counts predict.

// File: rtl/ova_pkg.sv
`timescale 1ns/1ps
package ova_pkg;
   // width of an index over n items, never below one bit
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ova_ovc_track.sv
`timescale 1ns/1ps
module ova_ovc_track #(
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc,
   input  logic          take,
   input  logic          give,
   input  logic          leave,
   output logic          room,
   output logic [CW-1:0] cred,
   output logic [CW-1:0] pkts
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cred <= FULL_CNT;
         pkts <= '0;
      end else begin
         cred <= cred - CW'(take) + CW'(give);
         pkts <= pkts + CW'(alloc) - CW'(leave);
      end
   end

   assign room = (cred != '0) && (pkts < FULL_CNT);
endmodule

// File: rtl/ova_vc_pick.sv
`timescale 1ns/1ps
module ova_vc_pick #(
   parameter int NP    = 5,
   parameter int NV    = 2,
   parameter int ESC   = 1,
   parameter int FW    = 6,
   parameter int PW    = 3,
   parameter int VW    = 1,
   parameter int CW    = 3
) (
   input  logic             valid,
   input  logic             dor,
   input  logic             alt_ok,
   input  logic [PW-1:0]    port_a,
   input  logic [PW-1:0]    port_b,
   input  logic [FW-1:0]    fob_in,
   input  logic [NP*NV-1:0] room,
   input  logic [NP*NV*CW-1:0] pkts,
   output logic             want,
   output logic [PW-1:0]    want_port,
   output logic [VW-1:0]    want_vc,
   output logic [FW-1:0]    fob_out
);
   localparam logic [FW:0] FOB_MAX = {1'b0, {FW{1'b1}}};

   logic          full_a, full_b, found;
   logic [CW-1:0] best_cnt;
   logic [FW:0]   fob_sum;

   always_comb begin
      full_a    = 1'b0;
      full_b    = 1'b0;
      found     = 1'b0;
      best_cnt  = '0;
      want_port = '0;
      want_vc   = '0;
      for (int k = 0; k < 2; k++) begin
         logic [PW-1:0] pk;
         logic          use_k, in_rng, any_elig, any_room;
         pk       = (k == 0) ? port_a : port_b;
         use_k    = (k == 0) || (alt_ok && !dor);
         in_rng   = int'(pk) < NP;
         any_elig = 1'b0;
         any_room = 1'b0;
         for (int v = 0; v < NV; v++) begin
            int            idx;
            logic          elig;
            logic [CW-1:0] cnt;
            idx  = in_rng ? (int'(pk) * NV + v) : 0;
            elig = valid && use_k && in_rng && (dor || (v >= ESC));
            cnt  = pkts[idx*CW +: CW];
            if (elig) begin
               any_elig = 1'b1;
               if (room[idx]) begin
                  any_room = 1'b1;
                  if (!found || (cnt < best_cnt)) begin
                     found     = 1'b1;
                     best_cnt  = cnt;
                     want_port = pk;
                     want_vc   = VW'(v);
                  end
               end
            end
         end
         if (k == 0) full_a = any_elig && !any_room;
         else        full_b = any_elig && !any_room;
      end
      want    = found;
      fob_sum = {1'b0, fob_in} + (FW+1)'(full_a) + (FW+1)'(full_b);
      fob_out = (fob_sum > FOB_MAX) ? FOB_MAX[FW-1:0] : fob_sum[FW-1:0];
   end
endmodule

// File: rtl/ova_rr_arb.sv
`timescale 1ns/1ps
module ova_rr_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   generate
      if (N == 1) begin : g_single
         assign gnt = req;
      end else begin : g_rotate
         logic [IW-1:0] ptr;
         logic          hit;
         int            win;

         always_comb begin
            gnt = '0;
            hit = 1'b0;
            win = 0;
            for (int off = 0; off < N; off++) begin
               int j;
               j = int'(ptr) + off;
               if (j >= N) j = j - N;
               if (!hit && req[j]) begin
                  gnt[j] = 1'b1;
                  hit    = 1'b1;
                  win    = j;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ptr <= '0;
            else if (hit) ptr <= (win == N - 1) ? '0 : IW'(win + 1);
         end
      end
   endgenerate
endmodule

// File: rtl/occ_vc_alloc.sv
`timescale 1ns/1ps
module occ_vc_alloc import ova_pkg::*; #(
   parameter int NI    = 4,
   parameter int NP    = 5,
   parameter int NV    = 2,
   parameter int ESC   = 1,
   parameter int DEPTH = 4,
   parameter int FW    = 6,
   parameter int PW    = idx_w(NP),
   parameter int VW    = idx_w(NV),
   parameter int NO    = NP * NV
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NI-1:0]    rq_valid,
   input  logic [NI-1:0]    rq_dor,
   input  logic [NI-1:0]    rq_alt_ok,
   input  logic [NI*PW-1:0] rq_port_a,
   input  logic [NI*PW-1:0] rq_port_b,
   input  logic [NI*FW-1:0] rq_fob,
   input  logic [NO-1:0]    crd_take,
   input  logic [NO-1:0]    crd_give,
   input  logic [NO-1:0]    pkt_leave,
   output logic [NI-1:0]    gr_valid,
   output logic [NI*PW-1:0] gr_port,
   output logic [NI*VW-1:0] gr_vc,
   output logic [NI*FW-1:0] gr_fob
);
   localparam int CW = $clog2(DEPTH + 1);

   // elaboration-time parameter checks
   if (NI < 1)                 begin : g_bad_ni    $error("NI must be at least 1");            end
   if (NP < 2)                 begin : g_bad_np    $error("NP must be at least 2");            end
   if (NV < 1)                 begin : g_bad_nv    $error("NV must be at least 1");            end
   if (ESC < 0 || ESC >= NV)   begin : g_bad_esc   $error("ESC must lie in 0..NV-1");          end
   if (DEPTH < 1)              begin : g_bad_depth $error("DEPTH must be at least 1");         end
   if (FW < 2)                 begin : g_bad_fw    $error("FW must be at least 2");            end
   if (NO != NP * NV)          begin : g_bad_no    $error("NO must equal NP*NV");              end

   logic [NO-1:0]    room;
   logic [NO*CW-1:0] cred_flat;
   logic [NO*CW-1:0] pkt_flat;
   logic [NO-1:0]    ovc_alloc;
   logic [NI-1:0]    want;
   logic [NI*PW-1:0] want_port;
   logic [NI*VW-1:0] want_vc;
   logic [NO*NI-1:0] gnt_mat;

   // stage one: each requester chooses one output VC
   for (genvar i = 0; i < NI; i++) begin : g_req
      ova_vc_pick #(
         .NP(NP), .NV(NV), .ESC(ESC), .FW(FW), .PW(PW), .VW(VW), .CW(CW)
      ) u_pick (
         .valid     (rq_valid[i]),
         .dor       (rq_dor[i]),
         .alt_ok    (rq_alt_ok[i]),
         .port_a    (rq_port_a[i*PW +: PW]),
         .port_b    (rq_port_b[i*PW +: PW]),
         .fob_in    (rq_fob[i*FW +: FW]),
         .room      (room),
         .pkts      (pkt_flat),
         .want      (want[i]),
         .want_port (want_port[i*PW +: PW]),
         .want_vc   (want_vc[i*VW +: VW]),
         .fob_out   (gr_fob[i*FW +: FW])
      );
   end

   // stage two: one arbiter and one occupancy tracker per output VC
   for (genvar o = 0; o < NO; o++) begin : g_ovc
      logic [NI-1:0] req_v;
      logic [NI-1:0] gnt_v;

      always_comb begin
         for (int i = 0; i < NI; i++)
            req_v[i] = want[i] &&
                       (int'(want_port[i*PW +: PW]) * NV + int'(want_vc[i*VW +: VW]) == o);
      end

      ova_rr_arb #(.N(NI)) u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (req_v),
         .gnt   (gnt_v)
      );

      assign gnt_mat[o*NI +: NI] = gnt_v;
      assign ovc_alloc[o]        = |gnt_v;

      ova_ovc_track #(.DEPTH(DEPTH), .CW(CW)) u_track (
         .clk   (clk),
         .rst_n (rst_n),
         .alloc (ovc_alloc[o]),
         .take  (crd_take[o]),
         .give  (crd_give[o]),
         .leave (pkt_leave[o]),
         .room  (room[o]),
         .cred  (cred_flat[o*CW +: CW]),
         .pkts  (pkt_flat[o*CW +: CW])
      );
   end

   always_comb begin
      gr_valid = '0;
      for (int o = 0; o < NO; o++)
         gr_valid = gr_valid | gnt_mat[o*NI +: NI];
   end

   assign gr_port = want_port;
   assign gr_vc   = want_vc;
endmodule

// File: rtl/occ_vc_alloc_chk.sv
`timescale 1ns/1ps
module occ_vc_alloc_chk #(
   parameter int NI    = 4,
   parameter int NP    = 5,
   parameter int NV    = 2,
   parameter int ESC   = 1,
   parameter int DEPTH = 4,
   parameter int FW    = 6,
   parameter int PW    = 3,
   parameter int VW    = 1,
   parameter int NO    = 10,
   parameter int CW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NI-1:0]    rq_valid,
   input logic [NI-1:0]    rq_dor,
   input logic [NI-1:0]    rq_alt_ok,
   input logic [NI*PW-1:0] rq_port_a,
   input logic [NI*PW-1:0] rq_port_b,
   input logic [NI*FW-1:0] rq_fob,
   input logic [NI-1:0]    gr_valid,
   input logic [NI*PW-1:0] gr_port,
   input logic [NI*VW-1:0] gr_vc,
   input logic [NI*FW-1:0] gr_fob,
   input logic [NO*CW-1:0] cred_flat,
   input logic [NO*CW-1:0] pkt_flat
);
   for (genvar i = 0; i < NI; i++) begin : g_in
      p_gnt_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
         gr_valid[i] |-> rq_valid[i]);

      p_escape_only_dor_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (gr_valid[i] && !rq_dor[i]) |-> (int'(gr_vc[i*VW +: VW]) >= ESC));

      p_port_on_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
         gr_valid[i] |-> ((gr_port[i*PW +: PW] == rq_port_a[i*PW +: PW]) ||
                          (rq_alt_ok[i] && !rq_dor[i] &&
                           gr_port[i*PW +: PW] == rq_port_b[i*PW +: PW])));

      p_fob_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
         rq_valid[i] |-> (gr_fob[i*FW +: FW] >= rq_fob[i*FW +: FW]));

      for (genvar j = i + 1; j < NI; j++) begin : g_pair
         p_one_winner_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (gr_valid[i] && gr_valid[j]) |->
               ({gr_port[i*PW +: PW], gr_vc[i*VW +: VW]} !=
                {gr_port[j*PW +: PW], gr_vc[j*VW +: VW]}));
      end
   end

   for (genvar o = 0; o < NO; o++) begin : g_out
      p_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(cred_flat[o*CW +: CW]) <= DEPTH) && (int'(pkt_flat[o*CW +: CW]) <= DEPTH));
   end
endmodule

bind occ_vc_alloc occ_vc_alloc_chk #(
   .NI(NI), .NP(NP), .NV(NV), .ESC(ESC), .DEPTH(DEPTH), .FW(FW),
   .PW(PW), .VW(VW), .NO(NO), .CW(CW)
) u_chk (.*);

// File: tb/occ_vc_alloc_bench.sv
`timescale 1ns/1ps
module occ_vc_alloc_bench;
   localparam int NI = 4, NP = 5, NV = 2, ESC = 1, DEPTH = 4, FW = 6;
   localparam int PW = 3, VW = 1, NO = NP * NV;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NI-1:0]    rq_valid, rq_dor, rq_alt_ok;
   logic [NI*PW-1:0] rq_port_a, rq_port_b;
   logic [NI*FW-1:0] rq_fob;
   logic [NO-1:0]    crd_take, crd_give, pkt_leave;
   logic [NI-1:0]    gr_valid;
   logic [NI*PW-1:0] gr_port;
   logic [NI*VW-1:0] gr_vc;
   logic [NI*FW-1:0] gr_fob;

   int checks = 0;
   int failures = 0;

   occ_vc_alloc #(.NI(NI), .NP(NP), .NV(NV), .ESC(ESC), .DEPTH(DEPTH), .FW(FW)) u_occ_vc_alloc (
      .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_dor(rq_dor), .rq_alt_ok(rq_alt_ok),
      .rq_port_a(rq_port_a), .rq_port_b(rq_port_b), .rq_fob(rq_fob),
      .crd_take(crd_take), .crd_give(crd_give), .pkt_leave(pkt_leave),
      .gr_valid(gr_valid), .gr_port(gr_port), .gr_vc(gr_vc), .gr_fob(gr_fob));

   always #2.5 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic clear_rq();
      rq_valid = '0; rq_dor = '0; rq_alt_ok = '0;
      rq_port_a = '0; rq_port_b = '0; rq_fob = '0;
   endtask

   task automatic set_rq(input int i, input bit dor, input bit alt, input int pa, input int pb, input int fob);
      rq_valid[i] = 1'b1;
      rq_dor[i]   = dor;
      rq_alt_ok[i] = alt;
      rq_port_a[i*PW +: PW] = PW'(pa);
      rq_port_b[i*PW +: PW] = PW'(pb);
      rq_fob[i*FW +: FW]    = FW'(fob);
   endtask

   task automatic do_reset();
      clear_rq();
      crd_take = '0; crd_give = '0; pkt_leave = '0;
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic drain(input int o, input int n);
      for (int k = 0; k < n; k++) begin
         crd_take[o] = 1'b1;
         step();
         crd_take[o] = 1'b0;
      end
   endtask

   function automatic int gp(input int i); return int'(gr_port[i*PW +: PW]); endfunction
   function automatic int gv(input int i); return int'(gr_vc[i*VW +: VW]); endfunction
   function automatic int gf(input int i); return int'(gr_fob[i*FW +: FW]); endfunction

   task automatic t_reset_state();
      do_reset();
      #1;
      chk("R1 no grant when idle", int'(gr_valid), 0);
      set_rq(0, 1, 0, 2, 0, 7);
      #1;
      chk("R1 first grant valid", int'(gr_valid[0]), 1);
      chk("R1 first grant port", gp(0), 2);
      chk("R1 first grant lowest vc", gv(0), 0);
      chk("R1 fob unchanged", gf(0), 7);
      clear_rq();
      step();
   endtask

   task automatic t_eligibility();
      do_reset();
      set_rq(0, 0, 0, 3, 0, 0);
      #1;
      chk("R8 adaptive avoids escape vc", gv(0), 1);
      chk("R8 adaptive port", gp(0), 3);
      step();
      clear_rq();
      set_rq(0, 1, 1, 3, 4, 0);
      #1;
      chk("R8 dor ignores alt port", gp(0), 3);
      chk("R8 dor may use escape vc", gv(0), 0);
      clear_rq();
      step();
   endtask

   task automatic t_least_occupancy();
      do_reset();
      set_rq(0, 0, 0, 3, 0, 0);
      #1;
      step();
      clear_rq();
      set_rq(0, 0, 1, 3, 4, 0);
      #1;
      chk("R7 fewer packets on port b", gp(0), 4);
      chk("R9 grant raised count on port a", int'(gr_valid[0]), 1);
      step();
      #1;
      chk("R7 tie goes to port a", gp(0), 3);
      clear_rq();
      step();
   endtask

   task automatic t_full_credit();
      do_reset();
      drain(2 * NV + 1, DEPTH);
      set_rq(0, 0, 1, 2, 4, 3);
      #1;
      chk("R5 alternate port granted", gp(0), 4);
      chk("R2 credit-full vc skipped", int'(gr_valid[0]), 1);
      chk("R4 fob plus one", gf(0), 4);
      clear_rq();
      step();
      drain(4 * NV + 1, DEPTH);
      set_rq(0, 0, 1, 2, 4, 3);
      #1;
      chk("R6 both full no grant", int'(gr_valid[0]), 0);
      chk("R6 fob plus two", gf(0), 5);
      crd_give[2 * NV + 1] = 1'b1;
      step();
      crd_give = '0;
      #1;
      chk("R2 credit return reopens vc", int'(gr_valid[0]), 1);
      chk("R2 regranted port", gp(0), 2);
      chk("R4 only port b full", gf(0), 4);
      clear_rq();
      step();
   endtask

   task automatic t_full_packets();
      do_reset();
      for (int k = 0; k < 2 * DEPTH; k++) begin
         set_rq(0, 1, 0, 0, 0, 0);
         #1;
         chk("R7 alternating fewest vc", gv(0), k % 2);
         if (k == 2) chk("R3 shared vc granted again", int'(gr_valid[0]), 1);
         step();
      end
      set_rq(0, 1, 0, 0, 0, 10);
      #1;
      chk("R2 packet-full no grant", int'(gr_valid[0]), 0);
      chk("R4 fob one full port", gf(0), 11);
      set_rq(0, 1, 0, 0, 0, 63);
      #1;
      chk("R4 fob saturates", gf(0), 63);
      clear_rq();
      pkt_leave[1] = 1'b1;
      step();
      pkt_leave = '0;
      set_rq(0, 1, 0, 0, 0, 0);
      #1;
      chk("R9 leave frees a slot", int'(gr_valid[0]), 1);
      chk("R9 freed vc chosen", gv(0), 1);
      clear_rq();
      step();
   endtask

   task automatic t_round_robin();
      do_reset();
      for (int i = 0; i < 3; i++) set_rq(i, 0, 0, 1, 0, 0);
      for (int k = 0; k < 4; k++) begin
         #1;
         chk("R10 rotating winner", int'(gr_valid[k % 3]), 1);
         chk("R11 single winner per vc", $countones(gr_valid), 1);
         step();
      end
      clear_rq();
      do_reset();
      set_rq(0, 0, 0, 1, 0, 0);
      set_rq(1, 0, 0, 2, 0, 0);
      set_rq(3, 1, 0, 1, 0, 0);
      #1;
      chk("R11 parallel grants", int'(gr_valid), 4'b1011);
      chk("R11 dor takes escape vc", gv(3), 0);
      clear_rq();
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset_state();
      t_eligibility();
      t_least_occupancy();
      t_full_credit();
      t_full_packets();
      t_round_robin();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule